// File: doc/BRIEF.md
# Pseudo-Sine Staircase Carrier Generator

This block sequences a differential carrier for a pair of 4-bit resistor-ladder converters. A phase counter advances once per oscillator clock. Each phase selects one of sixteen fixed codes that together approximate one sine period as a staircase, so the carrier frequency is the oscillator clock divided by sixteen. A 4 MHz clock gives a 250 kHz carrier. A second code of opposite polarity drives the other ladder.

A control input starts and stops the carrier, and it is active low. When the control is high, both codes rest at mid-scale and the transmit flag stays low. The flag is meant to close the analog switches that connect the ladder buffers to the line. When the control goes low, the positive code always starts from its minimum sample, which is the −90° point. When the control goes high again, the carrier is cut at whatever phase it has reached. The control input is synchronised inside the block. The start and stop latencies are both fixed counts of clock edges, and both lie well inside the required bounds.

Top module: `stair_carrier`

## Requirements
- R1: While running, the positive code repeats with a period of exactly 16 clock cycles.
- R2: After a start, the positive code steps once per clock through the hex values 0,1,3,6,9,C,E,F,F,E,C,9,6,3,1,0, beginning at the first value.
- R3: While running, `code_neg` equals 15 minus `code_pos`.
- R4: While the synchronised control is high, `code_pos` and `code_neg` are both the mid-scale value 8 and `tx_active` is 0.
- R5: A low level applied to `hold_req` before a rising edge yields `code_pos`=0, `code_neg`=15 and `tx_active`=1 after exactly two rising edges. After only one edge, the outputs are still idle.
- R6: A high level applied to `hold_req` while running yields the idle outputs after exactly two rising edges, whatever the phase. After one edge, the carrier is still running at the next step. The next start again begins at code 0.
- R7: A clock edge with `rst`=1 forces the idle outputs with `tx_active`=0 from that edge on. After `rst` is released with `hold_req` low, the carrier starts at code 0 two edges later.
- R8: `tx_active` is 1 exactly when a carrier code, rather than the idle value, is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, sixteen cycles per carrier period |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Asynchronous carrier control: 1 holds idle, 0 runs |
| code_pos | output | 4 | Positive ladder code |
| code_neg | output | 4 | Opposite-polarity ladder code |
| tx_active | output | 1 | High while the carrier runs; gates the line switches |

## Verification
The hardest case to reach is a stop that arrives in the middle of a period. It must cut the staircase at an arbitrary phase, and the following start must still begin from the minimum sample and not from the saved phase. The bench raises the control after a chosen number of steps. It checks that exactly one more step appears before the idle level, and then it restarts the carrier and walks the full table again. A reset applied while the carrier runs, with the control held low throughout, drives the same restart path through the synchroniser.

// File: rtl/stair_carrier_pkg.sv
package stair_carrier_pkg;

    localparam int PHASE_W = 4;
    localparam int CODE_W  = 4;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [CODE_W-1:0]  code_t;

    localparam code_t IDLE_CODE = code_t'(1 << (CODE_W - 1));
    localparam code_t FULL_CODE = code_t'((1 << CODE_W) - 1);

    typedef struct packed {
        code_t pos;
        code_t neg;
        logic  active;
    } carrier_out_t;

    // Staircase approximation of one sine period, starting at the minimum.
    function automatic code_t stair_code(input phase_t idx);
        code_t c;
        case (idx)
            4'd0:    c = 4'h0;
            4'd1:    c = 4'h1;
            4'd2:    c = 4'h3;
            4'd3:    c = 4'h6;
            4'd4:    c = 4'h9;
            4'd5:    c = 4'hC;
            4'd6:    c = 4'hE;
            4'd7:    c = 4'hF;
            4'd8:    c = 4'hF;
            4'd9:    c = 4'hE;
            4'd10:   c = 4'hC;
            4'd11:   c = 4'h9;
            4'd12:   c = 4'h6;
            4'd13:   c = 4'h3;
            4'd14:   c = 4'h1;
            default: c = 4'h0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stair_sync.sv
module stair_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/stair_phase.sv
module stair_phase
    import stair_carrier_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold_s,
    output phase_t phase,
    output logic   running
);
    always_ff @(posedge clk) begin
        if (rst || hold_s) phase <= '0;
        else               phase <= phase + 1'b1;
    end

    assign running = ~hold_s;
endmodule

// File: rtl/stair_encode.sv
module stair_encode
    import stair_carrier_pkg::*;
(
    input  phase_t       phase,
    input  logic         running,
    output carrier_out_t out
);
    code_t sample;

    always_comb begin
        sample = stair_code(phase);
        if (running) begin
            out.pos    = sample;
            out.neg    = FULL_CODE - sample;
            out.active = 1'b1;
        end else begin
            out.pos    = IDLE_CODE;
            out.neg    = IDLE_CODE;
            out.active = 1'b0;
        end
    end
endmodule

// File: rtl/stair_carrier.sv
module stair_carrier
    import stair_carrier_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold_req,
    output logic [3:0]  code_pos,
    output logic [3:0]  code_neg,
    output logic        tx_active
);
    logic         hold_s;
    phase_t       phase;
    logic         running;
    carrier_out_t cout;

    stair_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (hold_req),
        .dout (hold_s)
    );

    stair_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .hold_s  (hold_s),
        .phase   (phase),
        .running (running)
    );

    stair_encode u_encode (
        .phase   (phase),
        .running (running),
        .out     (cout)
    );

    assign code_pos  = cout.pos;
    assign code_neg  = cout.neg;
    assign tx_active = cout.active;

    AST_OPPOSITE_POLARITY: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> (4'(code_pos + code_neg) == 4'hF)); // R3

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> (code_pos == 4'h8 && code_neg == 4'h8)); // R4

    AST_START_AT_MIN: assert property (@(posedge clk) disable iff (rst)
        (tx_active && !$past(tx_active)) |-> (code_pos == 4'h0)); // R5

    AST_STEP_AFTER_MIN: assert property (@(posedge clk) disable iff (rst)
        (tx_active && !$past(tx_active)) |=> (!tx_active || code_pos == 4'h1)); // R2

    AST_FLAG_TRACKS_CODE: assert property (@(posedge clk) disable iff (rst)
        (code_pos != 4'h8) |-> tx_active); // R8
endmodule

// File: tb/stair_carrier_bench.sv
module stair_carrier_bench;
    localparam int CLK_PERIOD = 250;

    localparam logic [3:0] EXP_STAIR [16] = '{
        4'h0, 4'h1, 4'h3, 4'h6, 4'h9, 4'hC, 4'hE, 4'hF,
        4'hF, 4'hE, 4'hC, 4'h9, 4'h6, 4'h3, 4'h1, 4'h0
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hold_req = 1'b1;
    logic [3:0] code_pos, code_neg;
    logic       tx_active;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    stair_carrier u_stair_carrier (
        .clk       (clk),
        .rst       (rst),
        .hold_req  (hold_req),
        .code_pos  (code_pos),
        .code_neg  (code_neg),
        .tx_active (tx_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [3:0] ep, input logic [3:0] en,
                         input logic et);
        checks++;
        if (code_pos !== ep || code_neg !== en || tx_active !== et) begin
            failures++;
            $display("FAIL %s: actual pos=%h neg=%h tx=%b expected pos=%h neg=%h tx=%b",
                     req, code_pos, code_neg, tx_active, ep, en, et);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic walk(input string req, input int first, input int count);
        for (int k = 0; k < count; k++) begin
            check(req, EXP_STAIR[(first + k) % 16], 4'hF - EXP_STAIR[(first + k) % 16], 1'b1);
            step(1);
        end
    endtask

    initial begin
        step(3);
        check("R7 reset idle", 4'h8, 4'h8, 1'b0);
        rst = 1'b0;
        step(4);
        check("R4 hold high idle", 4'h8, 4'h8, 1'b0);

        // start: one edge later still idle, two edges later code 0
        hold_req = 1'b0;
        step(1);
        check("R5 one edge still idle", 4'h8, 4'h8, 1'b0);
        step(1);
        walk("R1 R2 R3 R8 first period", 0, 16);
        walk("R1 second period repeats", 0, 16);

        // stop mid-period: we are now at index 0; advance to index 5
        step(5);
        check("R2 index 5", 4'hC, 4'h3, 1'b1);
        hold_req = 1'b1;
        step(1);
        check("R6 one edge still running", 4'hE, 4'h1, 1'b1);
        step(1);
        check("R6 idle after stop", 4'h8, 4'h8, 1'b0);
        step(3);
        check("R4 idle held", 4'h8, 4'h8, 1'b0);

        // restart from minimum
        hold_req = 1'b0;
        step(2);
        walk("R6 restart from code 0", 0, 10);

        // reset while running, control low throughout
        rst = 1'b1;
        step(1);
        check("R7 reset forces idle", 4'h8, 4'h8, 1'b0);
        step(2);
        check("R7 reset held idle", 4'h8, 4'h8, 1'b0);
        rst = 1'b0;
        step(1);
        check("R7 one edge after release idle", 4'h8, 4'h8, 1'b0);
        step(1);
        walk("R7 start after reset", 0, 16);

        // stop at the top plateau index 7, then check wrap of count
        step(7);
        check("R2 index 7", 4'hF, 4'h0, 1'b1);
        hold_req = 1'b1;
        step(2);
        check("R6 stop at peak", 4'h8, 4'h8, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule